// File: doc/BRIEF.md
# Single-Bus Multicycle Processor Core

This block is a small 32-bit processor that runs four integer instructions (register add, register AND, word load and word store) through a datapath built around one shared internal bus. Every clock cycle exactly one source drives the bus. Any mix of the program counter, the ALU operand latch, the ALU result latch, the memory address and data registers, the instruction register and the register file may capture it. The ALU reads its first operand from a holding latch (Y) and its second from the bus, and it leaves its result in a second latch (Z).

A hardwired state machine steps through named control states. Each state drives one set of control fields. All instructions share a four-state fetch. The last fetch state tests the instruction register against an ordered list of mask/match rules and jumps to the sequence of the first rule that matches. An instruction that matches no rule stops the core in a halt state. Memory is reached through single-cycle read and write strobes. Reads complete when the memory raises a completion handshake, so the cycles per instruction depend on memory latency. Writes are issued and left to finish on their own.

Top module: `sbus_core`

## Requirements
- R1: While reset is high, `mem_rd`, `mem_wr` and `halted` are low. The first read after reset is the fetch from byte address 0.
- R2: Instructions are fetched from consecutive word addresses (PC, PC+4, ...). Each read is a single-cycle `mem_rd` pulse, and `mem_addr` holds the address during that pulse.
- R3: After issuing a read, the core holds its state until `mem_mfc` is high. It captures `mem_rdata` in that cycle, so results do not depend on how many cycles the memory takes.
- R4: Register add (opcode field [31:26]=0, function field [5:0]=0x20, sources in [25:21] and [20:16], destination in [15:11]) writes the 32-bit wrapped sum.
- R5: Register AND (opcode 0, function 0x24, same fields as R4) writes the bitwise AND.
- R6: Word load (opcode 0x23, base in [25:21], target in [20:16]) reads byte address base + sign-extended [15:0], and writes the returned word to the target register.
- R7: Word store (opcode 0x2B, same fields as R6) pulses `mem_wr` for one cycle, with `mem_addr` set to base + sign-extended offset and `mem_wdata` set to the target register. The core does not wait for any completion.
- R8: Register 0 reads as zero, and writes to it have no effect.
- R9: A word that matches no rule (for example function 0x22 with opcode 0) sets `halted`. `halted` stays high until reset, and no later memory strobes occur.
- R10: Each control state takes one cycle, except the wait states, which take one more cycle per cycle of memory latency. With a read latency of L cycles (handshake L cycles after the strobe), add and AND take 7+L cycles, store takes 8+L, load takes 9+2L, and an illegal word raises `halted` 4+L cycles after its fetch starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rd | output | 1 | Read strobe, one cycle per read |
| mem_wr | output | 1 | Write strobe, one cycle per write |
| mem_addr | output | W | Byte address of the access |
| mem_wdata | output | W | Data to be written |
| mem_rdata | input | W | Data returned by memory |
| mem_mfc | input | 1 | Memory read completion handshake |
| halted | output | 1 | Core has stopped on an unmatched instruction |

## Verification
The embedded assertions check these properties on every cycle:
- both strobes are single-cycle pulses and are never high together;
- the program counter only ever steps by four;
- a wait state holds until the handshake arrives;
- once halted, the core stays halted and silent.

The arithmetic results, the sign extension of negative offsets, the zero register and the cycle counts per instruction can only be shown by the bench's programs. The bench runs the same program at three memory latencies and compares every read address and every stored word against a queue of expected accesses.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  typedef enum logic [4:0] {
    ST_F1, ST_F2, ST_F3, ST_F4,
    ST_ADD1, ST_ADD2, ST_ADD3,
    ST_AND1, ST_AND2, ST_AND3,
    ST_LW1, ST_LW2, ST_LW3, ST_LW4, ST_LW5,
    ST_SW1, ST_SW2, ST_SW3, ST_SW4,
    ST_HALT
  } state_e;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_PC, SRC_Z, SRC_MDR, SRC_REG, SRC_IMM, SRC_FOUR
  } src_e;

  typedef enum logic [1:0] {SEL_RS, SEL_RT, SEL_RD} rsel_e;

  typedef enum logic {ALU_ADD, ALU_AND} alu_e;

  typedef struct packed {
    src_e  src;
    rsel_e rsel;
    alu_e  alu;
    logic  y_in;
    logic  z_in;
    logic  mar_in;
    logic  mdr_in;
    logic  ir_in;
    logic  pc_in;
    logic  reg_in;
    logic  rd_req;
    logic  wr_req;
    logic  wait_mfc;
  } ctl_t;

  // Ordered dispatch rules: the first hit wins.
  localparam int NRULE = 4;
  localparam logic [31:0] RULE_MASK  [NRULE] = '{32'hFC00_003F, 32'hFC00_003F,
                                                 32'hFC00_0000, 32'hFC00_0000};
  localparam logic [31:0] RULE_MATCH [NRULE] = '{32'h0000_0020, 32'h0000_0024,
                                                 32'h8C00_0000, 32'hAC00_0000};
  localparam state_e      RULE_DEST  [NRULE] = '{ST_ADD1, ST_AND1, ST_LW1, ST_SW1};

  function automatic state_e dispatch(input logic [31:0] word);
    state_e dest;
    logic   hit;
    dest = ST_HALT;
    hit  = 1'b0;
    for (int i = 0; i < NRULE; i++) begin
      if (!hit && ((word & RULE_MASK[i]) == RULE_MATCH[i])) begin
        dest = RULE_DEST[i];
        hit  = 1'b1;
      end
    end
    return dest;
  endfunction

endpackage

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_e         op,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [N];

  // Entry 0 is never written; its read is forced to zero.
  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) cells[waddr] <= wdata;
  end

  assign rdata = (raddr == '0) ? '0 : cells[raddr];
endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] ir,
  input  logic        mfc,
  output ctl_t        ctl,
  output logic        halted
);
  state_e state_q, state_n;

  always_comb begin
    ctl     = '0;
    state_n = state_q;
    case (state_q)
      ST_F1: begin
        ctl.src = SRC_PC; ctl.mar_in = 1'b1; ctl.y_in = 1'b1; ctl.rd_req = 1'b1;
        state_n = ST_F2;
      end
      ST_F2: begin
        ctl.src = SRC_FOUR; ctl.alu = ALU_ADD; ctl.z_in = 1'b1; ctl.wait_mfc = 1'b1;
        if (mfc) state_n = ST_F3;
      end
      ST_F3: begin
        ctl.src = SRC_MDR; ctl.ir_in = 1'b1;
        state_n = ST_F4;
      end
      ST_F4: begin
        ctl.src = SRC_Z; ctl.pc_in = 1'b1;
        state_n = dispatch(ir);
      end
      ST_ADD1, ST_AND1: begin
        ctl.src = SRC_REG; ctl.rsel = SEL_RS; ctl.y_in = 1'b1;
        state_n = (state_q == ST_ADD1) ? ST_ADD2 : ST_AND2;
      end
      ST_ADD2, ST_AND2: begin
        ctl.src = SRC_REG; ctl.rsel = SEL_RT; ctl.z_in = 1'b1;
        ctl.alu = (state_q == ST_ADD2) ? ALU_ADD : ALU_AND;
        state_n = (state_q == ST_ADD2) ? ST_ADD3 : ST_AND3;
      end
      ST_ADD3, ST_AND3: begin
        ctl.src = SRC_Z; ctl.rsel = SEL_RD; ctl.reg_in = 1'b1;
        state_n = ST_F1;
      end
      ST_LW1: begin
        ctl.src = SRC_REG; ctl.rsel = SEL_RS; ctl.y_in = 1'b1;
        state_n = ST_LW2;
      end
      ST_LW2: begin
        ctl.src = SRC_IMM; ctl.alu = ALU_ADD; ctl.z_in = 1'b1;
        state_n = ST_LW3;
      end
      ST_LW3: begin
        ctl.src = SRC_Z; ctl.mar_in = 1'b1; ctl.rd_req = 1'b1;
        state_n = ST_LW4;
      end
      ST_LW4: begin
        ctl.wait_mfc = 1'b1;
        if (mfc) state_n = ST_LW5;
      end
      ST_LW5: begin
        ctl.src = SRC_MDR; ctl.rsel = SEL_RT; ctl.reg_in = 1'b1;
        state_n = ST_F1;
      end
      ST_SW1: begin
        ctl.src = SRC_REG; ctl.rsel = SEL_RT; ctl.mdr_in = 1'b1;
        state_n = ST_SW2;
      end
      ST_SW2: begin
        ctl.src = SRC_REG; ctl.rsel = SEL_RS; ctl.y_in = 1'b1;
        state_n = ST_SW3;
      end
      ST_SW3: begin
        ctl.src = SRC_IMM; ctl.alu = ALU_ADD; ctl.z_in = 1'b1;
        state_n = ST_SW4;
      end
      ST_SW4: begin
        ctl.src = SRC_Z; ctl.mar_in = 1'b1; ctl.wr_req = 1'b1;
        state_n = ST_F1;
      end
      default: state_n = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_F1;
      halted  <= 1'b0;
    end else begin
      state_q <= state_n;
      halted  <= (state_n == ST_HALT);
    end
  end

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ctl.wait_mfc && !mfc) |=> (state_q == $past(state_q))); // R3
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R9
endmodule

// File: rtl/sbus_core.sv
module sbus_core
  import sbus_pkg::*;
#(
  parameter int          W        = 32,
  parameter int          NREG     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic         clk,
  input  logic         rst,
  output logic         mem_rd,
  output logic         mem_wr,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_mfc,
  output logic         halted
);
  localparam int RAW = $clog2(NREG);

  ctl_t           ctl;
  logic [W-1:0]   bus, alu_res, rf_rdata, imm_ext;
  logic [W-1:0]   pc_q, mar_q, mdr_q, y_q, z_q;
  logic [31:0]    ir_q;
  logic [4:0]     fld;
  logic [RAW-1:0] rf_addr;
  logic           armed_q;

  sbus_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .ir     (ir_q),
    .mfc    (mem_mfc),
    .ctl    (ctl),
    .halted (halted)
  );

  always_comb begin
    case (ctl.rsel)
      SEL_RS:  fld = ir_q[25:21];
      SEL_RT:  fld = ir_q[20:16];
      default: fld = ir_q[15:11];
    endcase
  end
  assign rf_addr = fld[RAW-1:0];
  assign imm_ext = {{(W-16){ir_q[15]}}, ir_q[15:0]};

  sbus_regfile #(.W(W), .N(NREG)) u_rf (
    .clk   (clk),
    .we    (ctl.reg_in),
    .waddr (rf_addr),
    .wdata (bus),
    .raddr (rf_addr),
    .rdata (rf_rdata)
  );

  // The single shared bus: one source per cycle.
  always_comb begin
    case (ctl.src)
      SRC_PC:   bus = pc_q;
      SRC_Z:    bus = z_q;
      SRC_MDR:  bus = mdr_q;
      SRC_REG:  bus = rf_rdata;
      SRC_IMM:  bus = imm_ext;
      SRC_FOUR: bus = W'(4);
      default:  bus = '0;
    endcase
  end

  sbus_alu #(.W(W)) u_alu (
    .a  (y_q),
    .b  (bus),
    .op (ctl.alu),
    .y  (alu_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= W'(RESET_PC);
      mar_q   <= '0;
      mdr_q   <= '0;
      y_q     <= '0;
      z_q     <= '0;
      ir_q    <= '0;
      mem_rd  <= 1'b0;
      mem_wr  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (ctl.pc_in)  pc_q  <= bus;
      if (ctl.mar_in) mar_q <= bus;
      if (ctl.y_in)   y_q   <= bus;
      if (ctl.z_in)   z_q   <= alu_res;
      if (ctl.ir_in)  ir_q  <= bus[31:0];
      if (ctl.wait_mfc && mem_mfc) mdr_q <= mem_rdata;
      else if (ctl.mdr_in)         mdr_q <= bus;
      mem_rd <= ctl.rd_req;
      mem_wr <= ctl.wr_req;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd); // R2
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> !mem_wr); // R7
  AST_NO_RD_WR: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R7
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (armed_q && (pc_q != $past(pc_q))) |-> (pc_q == $past(pc_q) + W'(4))); // R2
  AST_R0_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((ctl.src == SRC_REG) && (rf_addr == '0)) |-> (bus == '0)); // R8
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_rd && !mem_wr)); // R9
endmodule

// File: tb/test_sbus_core.sv
module test_sbus_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_rd, mem_wr, halted;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_mfc = 1'b0;

  int errors = 0;
  int checks = 0;
  int lat = 1;
  int mcnt = 0;
  logic [31:0] maddr_q = '0;
  logic [31:0] mem [256];

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } exp_t;
  exp_t rd_q[$];
  exp_t wr_q[$];
  exp_t re, we_e;

  always #2 clk = ~clk;

  sbus_core i_sbus_core (
    .clk       (clk),
    .rst       (rst),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_mfc   (mem_mfc),
    .halted    (halted)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Behavioural memory: completion arrives lat cycles after the read strobe.
  always @(posedge clk) begin
    mem_mfc <= 1'b0;
    if (rst) begin
      mcnt <= 0;
    end else begin
      if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;
      if (mem_rd) begin
        maddr_q <= mem_addr;
        if (lat <= 1) begin
          mem_mfc   <= 1'b1;
          mem_rdata <= mem[mem_addr[9:2]];
        end else begin
          mcnt <= lat - 1;
        end
      end else if (mcnt != 0) begin
        mcnt <= mcnt - 1;
        if (mcnt == 1) begin
          mem_mfc   <= 1'b1;
          mem_rdata <= mem[maddr_q[9:2]];
        end
      end
    end
  end

  // Monitor: pop expected accesses as the design produces them.
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd) begin
        if (rd_q.size() == 0) chk(1'b0, "R9", "unexpected read", mem_addr, 32'h0);
        else begin
          re = rd_q.pop_front();
          chk(mem_addr == re.addr, re.tag, "read address", mem_addr, re.addr);
        end
      end
      if (mem_wr) begin
        if (wr_q.size() == 0) chk(1'b0, "R9", "unexpected write", mem_addr, 32'h0);
        else begin
          we_e = wr_q.pop_front();
          chk(mem_addr == we_e.addr, we_e.tag, "write address", mem_addr, we_e.addr);
          chk(mem_wdata == we_e.data, we_e.tag, "write data", mem_wdata, we_e.data);
        end
      end
    end
  end

  function automatic logic [31:0] rr(input int rs, input int rt, input int rd, input int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] mi(input int op, input int rs, input int rt, input logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  task automatic push_rd(input logic [31:0] a, input string t);
    exp_t e;
    e.addr = a; e.data = '0; e.tag = t;
    rd_q.push_back(e);
  endtask
  task automatic push_wr(input logic [31:0] a, input logic [31:0] d, input string t);
    exp_t e;
    e.addr = a; e.data = d; e.tag = t;
    wr_q.push_back(e);
  endtask

  task automatic run_prog(input int l, input string ctag);
    logic [31:0] d0, d1, d2, d3, d4;
    int cyc, expc;
    d0 = 32'h1234_5678; d1 = 32'h0F0F_00FF; d2 = 32'hFFFF_FFFF;
    d3 = 32'h8000_0001; d4 = 32'h0000_0120;
    rst = 1'b1;
    lat = l;
    rd_q.delete();
    wr_q.delete();
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[0]  = mi(6'h23, 0, 1, 16'h0100);
    mem[1]  = mi(6'h23, 0, 2, 16'h0104);
    mem[2]  = rr(1, 2, 3, 6'h20);
    mem[3]  = mi(6'h2B, 0, 3, 16'h0180);
    mem[4]  = rr(1, 2, 4, 6'h24);
    mem[5]  = mi(6'h2B, 0, 4, 16'h0184);
    mem[6]  = mi(6'h23, 0, 5, 16'h0108);
    mem[7]  = rr(5, 5, 6, 6'h20);
    mem[8]  = mi(6'h2B, 0, 6, 16'h0188);
    mem[9]  = rr(1, 2, 0, 6'h20);
    mem[10] = mi(6'h2B, 0, 0, 16'h018C);
    mem[11] = mi(6'h23, 0, 9, 16'h0110);
    mem[12] = mi(6'h23, 9, 8, 16'hFFEC);
    mem[13] = mi(6'h2B, 9, 8, 16'hFFF8);
    mem[14] = rr(1, 2, 11, 6'h22);
    mem[15] = mi(6'h2B, 0, 1, 16'h0190);
    mem[64] = d0; mem[65] = d1; mem[66] = d2; mem[67] = d3; mem[68] = d4;
    repeat (3) @(negedge clk);
    chk(mem_rd == 1'b0, "R1", "read strobe in reset", 32'(mem_rd), 32'h0);
    chk(mem_wr == 1'b0, "R1", "write strobe in reset", 32'(mem_wr), 32'h0);
    chk(halted == 1'b0, "R1", "halted in reset", 32'(halted), 32'h0);
    // Expected reads in order: fetches and load data addresses.
    push_rd(32'h00, "R1");  push_rd(32'h100, "R6");
    push_rd(32'h04, "R2");  push_rd(32'h104, "R6");
    for (int i = 2; i <= 5; i++) push_rd(32'(4 * i), "R2");
    push_rd(32'h18, "R2");  push_rd(32'h108, "R6");
    for (int i = 7; i <= 10; i++) push_rd(32'(4 * i), "R2");
    push_rd(32'h2C, "R2");  push_rd(32'h110, "R6");
    push_rd(32'h30, "R2");  push_rd(32'h10C, "R6");
    push_rd(32'h34, "R2");
    push_rd(32'h38, "R2");
    // Expected stores.
    push_wr(32'h180, d0 + d1, "R4");
    push_wr(32'h184, d0 & d1, "R5");
    push_wr(32'h188, d2 + d2, "R4");
    push_wr(32'h18C, 32'h0, "R8");
    push_wr(d4 - 32'd8, d3, "R6");
    rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < 2000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    expc = 5 * (9 + 2 * l) + 4 * (7 + l) + 5 * (8 + l) + 4 + l;
    chk(cyc == expc, ctag, "cycles until halt", 32'(cyc), 32'(expc));
    repeat (20) @(negedge clk);
    chk(halted == 1'b1, "R9", "halted stays set", 32'(halted), 32'h1);
    chk(rd_q.size() == 0, "R2", "reads left pending", 32'(rd_q.size()), 32'h0);
    chk(wr_q.size() == 0, "R7", "stores left pending", 32'(wr_q.size()), 32'h0);
    chk(mem[70] == d3, "R7", "stored word at negative offset", mem[70], d3);
  endtask

  initial begin
    run_prog(1, "R10");
    run_prog(4, "R3");
    run_prog(2, "R10");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule